// File: doc/BRIEF.md
# I3C Target Address and Command Handler

This block is the target-side owner of a device's bus address on a two-wire I3C bus. A bit-level front end turns the bus into a stream of frame events: start (or repeated start), address header, data byte and stop. The block takes one event per cycle. For every header and every data byte it returns a registered acknowledge decision one cycle later, which the front end drives onto the bus.

The device answers at a fixed static address until the controller gives it a dynamic 7-bit address. Any frame addressed to the shared broadcast address 7'h7E (write) carries a bus-management command. The block executes a small set of these commands:

- Broadcast commands act on every device.
- Directed commands name their target in the first payload byte.

Together they can assign, replace or clear the dynamic address and switch event generation on or off. The event-enable flags go to the logic that raises interrupts, controller-role requests and join requests.

The unique-ID arbitration phase of address assignment is not handled. A device with no dynamic address receives one through a directed set-new-address command aimed at its static address.

Top module: `bus_target_ctl`

## Requirements
- R1: A synchronous active-low reset clears the dynamic-address-valid flag, sets every event enable to 1 and holds the acknowledge outputs low. Reset wins over an event presented in the same cycle.
- R2: A header whose bits [7:1] equal the active address is acknowledged. The active address is the dynamic address when it is valid, otherwise the static address. Data bytes of that frame are acknowledged. Any header naming another non-broadcast address is not acknowledged.
- R3: A header 8'hFC (broadcast address 7'h7E, write bit 0) is acknowledged. The broadcast address with the read bit set (8'hFD) is not.
- R4: In a broadcast frame, the first data byte is the command identifier. Only 8'h00, 8'h01, 8'h06, 8'h80, 8'h81 and 8'h88 are acknowledged. Any other identifier is not acknowledged, and the rest of that frame changes no state.
- R5: Broadcast enable-events (8'h00) and disable-events (8'h01) take one mask byte, which is acknowledged. Each bit i in 1 sets (enable) or clears (disable) event flag i. Bit 0 is interrupt requests, bit 1 is controller-role requests and bit 2 is join requests. Flags are unchanged at all other times.
- R6: Broadcast reset-address (8'h06) clears the dynamic-address-valid flag. The device then answers at its static address again.
- R7: For directed identifiers (8'h80 and above), the next byte names the target in bits [7:1]. It is acknowledged only if it equals the active address. Only then is the payload byte acted on: 8'h80 enables and 8'h81 disables by mask. On a mismatch, nothing changes and the rest of the frame is not acknowledged.
- R8: Directed set-new-address (8'h88) loads the dynamic address from payload bits [7:1] and marks it valid. From then on, headers match the new address and no longer the static one.
- R9: A set-new-address payload naming 7'h7E is not acknowledged and leaves the address unchanged.
- R10: A stop ends any command context. Data bytes that arrive before the next start and header are not acknowledged and change no state.
- R11: ack_vld is 1 exactly in the cycle after a header or data event. Start and stop produce none. ack_ok is never 1 without ack_vld.
- R12: Bytes that follow a command's last payload byte are not acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_vld | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | 0 start, 1 header, 2 data byte, 3 stop |
| ev_byte | input | 8 | Header byte (address in [7:1], read bit in [0]) or data byte |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle after a header/data event) |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| dyn_addr | output | 7 | Current dynamic address |
| dyn_valid | output | 1 | Dynamic address has been assigned |
| evt_en | output | NUM_EVT | Event enable flags |

## Verification
Two functions can fall on the same clock edge. The first pair is the synchronous reset and a set-new-address payload byte: the bench drives both in one cycle and expects the address to stay invalid, the enables to be all ones and no acknowledge. The second pair is a reset-address command and the following header match. Here the bench checks that the very next frame's header is judged against the static address and not the old dynamic one. A directed frame that names another target is followed by stray bytes, and the enables are read back to show they were untouched.

// File: rtl/bus_target_pkg.sv
// Shared types and constants for the target address/command handler.
// Assumes 7-bit addresses carried in bits [7:1] of a byte.
package bus_target_pkg;

    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

    // Frame event kinds as delivered by the bit-level front end.
    typedef enum logic [1:0] {
        EV_START = 2'd0,
        EV_HDR   = 2'd1,
        EV_DATA  = 2'd2,
        EV_STOP  = 2'd3
    } ev_kind_e;

    // Command identifiers (below 8'h80 broadcast, at or above directed).
    localparam logic [7:0] CMD_EVT_ON_ALL  = 8'h00;
    localparam logic [7:0] CMD_EVT_OFF_ALL = 8'h01;
    localparam logic [7:0] CMD_ADDR_RESET  = 8'h06;
    localparam logic [7:0] CMD_EVT_ON_ONE  = 8'h80;
    localparam logic [7:0] CMD_EVT_OFF_ONE = 8'h81;
    localparam logic [7:0] CMD_NEW_ADDR    = 8'h88;

    // Frame tracking states.
    typedef enum logic [2:0] {
        ST_IDLE,   // between frames
        ST_HDR,    // start seen, header expected
        ST_PRIV,   // private transfer to this device
        ST_CMD,    // broadcast header seen, identifier expected
        ST_BMASK,  // broadcast enable/disable mask expected
        ST_DTGT,   // directed command, target byte expected
        ST_DPAY,   // directed command, payload expected
        ST_SKIP    // nothing more to accept in this frame
    } frame_st_e;

    // True when the identifier is one this block executes.
    function automatic logic cmd_known(input logic [7:0] id);
        return (id == CMD_EVT_ON_ALL) || (id == CMD_EVT_OFF_ALL) ||
               (id == CMD_ADDR_RESET) || (id == CMD_EVT_ON_ONE) ||
               (id == CMD_EVT_OFF_ONE) || (id == CMD_NEW_ADDR);
    endfunction

endpackage

// File: rtl/tgt_addr_store.sv
// Holds the dynamic address and its valid flag and presents the address the
// device currently answers at. Assumes set and clear strobes never coincide.
module tgt_addr_store
    import bus_target_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STATIC_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_val,
    input  logic              clr_stb,
    output logic [ADDR_W-1:0] dyn_addr,
    output logic              dyn_valid,
    output logic [ADDR_W-1:0] active_addr
);

    // Address register: loaded by set-new-address, invalidated by reset-address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dyn_addr  <= '0;
            dyn_valid <= 1'b0;
        end else if (set_stb) begin
            dyn_addr  <= set_val;
            dyn_valid <= 1'b1;
        end else if (clr_stb) begin
            dyn_valid <= 1'b0;
        end
    end

    // Address to match headers and directed targets against.
    always_comb begin
        active_addr = dyn_valid ? dyn_addr : STATIC_ADDR;
    end

    // R6: a clear strobe leaves the address invalid.
    p_clr_invalidates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> !dyn_valid);

    // R9: the broadcast address is never taken as the device's own.
    p_no_bcast_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_valid |-> (dyn_addr != BCAST_ADDR));

    // R8: a set strobe installs exactly the offered value.
    p_set_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (dyn_valid && dyn_addr == $past(set_val)));

endmodule

// File: rtl/tgt_event_flags.sv
// One enable flag per event type, set or cleared by mask strobes.
// Assumes set and clear masks are never active in the same cycle.
module tgt_event_flags #(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_mask,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] en
);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        // Per-event enable: reset to on, then follows mask strobes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en[g] <= 1'b1;
            else if (set_mask[g])
                en[g] <= 1'b1;
            else if (clr_mask[g])
                en[g] <= 1'b0;
        end
    end

    // R5: the two masks never overlap.
    p_masks_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask & clr_mask) == '0);

    // R5: with no strobe the flags hold.
    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(en));

endmodule

// File: rtl/tgt_frame_fsm.sv
// Tracks the frame from the event stream, decides acknowledges and issues
// strobes to the address store and event flags. Assumes at most one event
// per cycle and that every frame opens with a start event.
module tgt_frame_fsm
    import bus_target_pkg::*;
#(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_vld,
    input  logic [1:0]         ev_kind,
    input  logic [7:0]         ev_byte,
    input  logic [ADDR_W-1:0]  active_addr,
    output logic               ack_vld,
    output logic               ack_ok,
    output logic               da_set,
    output logic [ADDR_W-1:0]  da_val,
    output logic               da_clr,
    output logic [NUM_EVT-1:0] ev_set,
    output logic [NUM_EVT-1:0] ev_clr
);

    frame_st_e   state, state_d;
    logic [7:0]  cmd_q, cmd_d;
    logic        rsp_d, hit_d;
    ev_kind_e    kind;
    logic [ADDR_W-1:0] byte_addr;

    assign kind      = ev_kind_e'(ev_kind);
    assign byte_addr = ev_byte[7:1];

    // Next-state, acknowledge and strobe decision for the presented event.
    always_comb begin
        state_d = state;
        cmd_d   = cmd_q;
        rsp_d   = 1'b0;
        hit_d   = 1'b0;
        da_set  = 1'b0;
        da_val  = byte_addr;
        da_clr  = 1'b0;
        ev_set  = '0;
        ev_clr  = '0;
        if (ev_vld) begin
            unique case (kind)
                EV_START: state_d = ST_HDR;
                EV_STOP:  state_d = ST_IDLE;
                EV_HDR: begin
                    rsp_d   = 1'b1;
                    state_d = ST_SKIP;
                    if (state == ST_HDR) begin
                        if (byte_addr == BCAST_ADDR && !ev_byte[0]) begin
                            hit_d   = 1'b1;
                            state_d = ST_CMD;
                        end else if (byte_addr == active_addr &&
                                     byte_addr != BCAST_ADDR) begin
                            hit_d   = 1'b1;
                            state_d = ST_PRIV;
                        end
                    end
                end
                EV_DATA: begin
                    rsp_d = 1'b1;
                    case (state)
                        ST_PRIV: hit_d = 1'b1;
                        ST_CMD: begin
                            state_d = ST_SKIP;
                            if (cmd_known(ev_byte)) begin
                                hit_d = 1'b1;
                                cmd_d = ev_byte;
                                if (ev_byte == CMD_ADDR_RESET)
                                    da_clr = 1'b1;
                                else if (ev_byte[7])
                                    state_d = ST_DTGT;
                                else
                                    state_d = ST_BMASK;
                            end
                        end
                        ST_BMASK: begin
                            hit_d   = 1'b1;
                            state_d = ST_SKIP;
                            if (cmd_q == CMD_EVT_ON_ALL)
                                ev_set = ev_byte[NUM_EVT-1:0];
                            else
                                ev_clr = ev_byte[NUM_EVT-1:0];
                        end
                        ST_DTGT: begin
                            state_d = ST_SKIP;
                            if (byte_addr == active_addr) begin
                                hit_d   = 1'b1;
                                state_d = ST_DPAY;
                            end
                        end
                        ST_DPAY: begin
                            state_d = ST_SKIP;
                            if (cmd_q == CMD_EVT_ON_ONE) begin
                                hit_d  = 1'b1;
                                ev_set = ev_byte[NUM_EVT-1:0];
                            end else if (cmd_q == CMD_EVT_OFF_ONE) begin
                                hit_d  = 1'b1;
                                ev_clr = ev_byte[NUM_EVT-1:0];
                            end else if (cmd_q == CMD_NEW_ADDR &&
                                         byte_addr != BCAST_ADDR) begin
                                hit_d  = 1'b1;
                                da_set = 1'b1;
                            end
                        end
                        default: hit_d = 1'b0;
                    endcase
                end
                default: state_d = state;
            endcase
        end
    end

    // Frame state and latched command identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            state <= state_d;
            cmd_q <= cmd_d;
        end
    end

    // Registered acknowledge decision for the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
        end else begin
            ack_vld <= rsp_d;
            ack_ok  <= hit_d;
        end
    end

    // R4: an unknown identifier is answered with no acknowledge.
    p_unknown_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && kind == EV_DATA && state == ST_CMD && !cmd_known(ev_byte))
        |=> (ack_vld && !ack_ok));

    // R10: a stop always returns the tracker to idle.
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && kind == EV_STOP) |=> (state == ST_IDLE));

    // R10: data outside a frame is never acknowledged.
    p_idle_data_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && kind == EV_DATA && state == ST_IDLE) |=> !ack_ok);

endmodule

// File: rtl/bus_target_ctl.sv
// Top of the target address and command handler: wires the frame tracker
// to the address store and event flags. Assumes a byte-level event stream
// from a separate bit-level front end, one event per cycle at most.
module bus_target_ctl
    import bus_target_pkg::*;
#(
    parameter logic [6:0] STATIC_ADDR = 7'h2A,
    parameter int         NUM_EVT     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_vld,
    input  logic [1:0]         ev_kind,
    input  logic [7:0]         ev_byte,
    output logic               ack_vld,
    output logic               ack_ok,
    output logic [6:0]         dyn_addr,
    output logic               dyn_valid,
    output logic [NUM_EVT-1:0] evt_en
);

    logic              da_set, da_clr;
    logic [ADDR_W-1:0] da_val, active_addr;
    logic [NUM_EVT-1:0] ev_set, ev_clr;

    tgt_frame_fsm #(.NUM_EVT(NUM_EVT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_vld     (ev_vld),
        .ev_kind    (ev_kind),
        .ev_byte    (ev_byte),
        .active_addr(active_addr),
        .ack_vld    (ack_vld),
        .ack_ok     (ack_ok),
        .da_set     (da_set),
        .da_val     (da_val),
        .da_clr     (da_clr),
        .ev_set     (ev_set),
        .ev_clr     (ev_clr)
    );

    tgt_addr_store #(.STATIC_ADDR(STATIC_ADDR)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_stb    (da_set),
        .set_val    (da_val),
        .clr_stb    (da_clr),
        .dyn_addr   (dyn_addr),
        .dyn_valid  (dyn_valid),
        .active_addr(active_addr)
    );

    tgt_event_flags #(.NUM_EVT(NUM_EVT)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (ev_set),
        .clr_mask (ev_clr),
        .en       (evt_en)
    );

    // R11: every header or data event gets a decision one cycle later.
    p_ack_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && (ev_kind == 2'd1 || ev_kind == 2'd2)) |=> ack_vld);

    // R11: no decision without a header or data event.
    p_no_spurious_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_vld && (ev_kind == 2'd1 || ev_kind == 2'd2)) |=> !ack_vld);

    // R11: an acknowledge is only given as a decision.
    p_ok_needs_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> ack_vld);

endmodule

// File: tb/bus_target_ctl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module bus_target_ctl_tb;

    localparam logic [1:0] K_S = 2'd0, K_H = 2'd1, K_D = 2'd2, K_P = 2'd3;
    localparam int NV = 33;

    // {requirement number, kind, byte, expected ack_vld, expected ack_ok}
    localparam logic [15:0] VEC [NV] = '{
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd2,  K_H, 8'h54, 1'b1, 1'b1},  // R2 static address
        {4'd2,  K_D, 8'h11, 1'b1, 1'b1},
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd2,  K_H, 8'h66, 1'b1, 1'b0},  // R2 foreign address
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd3,  K_H, 8'hFC, 1'b1, 1'b1},  // R3 broadcast write
        {4'd4,  K_D, 8'h01, 1'b1, 1'b1},
        {4'd5,  K_D, 8'h05, 1'b1, 1'b1},  // R5 disable mask
        {4'd12, K_D, 8'h00, 1'b1, 1'b0},  // R12 extra byte
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd3,  K_H, 8'hFD, 1'b1, 1'b0},  // R3 broadcast read
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd3,  K_H, 8'hFC, 1'b1, 1'b1},
        {4'd4,  K_D, 8'h88, 1'b1, 1'b1},
        {4'd7,  K_D, 8'h54, 1'b1, 1'b1},  // R7 target is static addr
        {4'd8,  K_D, 8'h2A, 1'b1, 1'b1},  // R8 new address 7'h15
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd8,  K_H, 8'h54, 1'b1, 1'b0},  // R8 static no longer answers
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd8,  K_H, 8'h2A, 1'b1, 1'b1},  // R8 new address answers
        {4'd11, K_P, 8'h00, 1'b0, 1'b0},
        {4'd11, K_S, 8'h00, 1'b0, 1'b0},
        {4'd3,  K_H, 8'hFC, 1'b1, 1'b1},
        {4'd4,  K_D, 8'h42, 1'b1, 1'b0},  // R4 unknown identifier
        {4'd4,  K_D, 8'h05, 1'b1, 1'b0},
        {4'd11, K_P, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_vld = 1'b0;
    logic [1:0] ev_kind = 2'd0;
    logic [7:0] ev_byte = 8'h00;
    logic       ack_vld, ack_ok, dyn_valid;
    logic [6:0] dyn_addr;
    logic [2:0] evt_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_target_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_kind(ev_kind),
        .ev_byte(ev_byte), .ack_vld(ack_vld), .ack_ok(ack_ok),
        .dyn_addr(dyn_addr), .dyn_valid(dyn_valid), .evt_en(evt_en)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one event for one cycle and return the decision that follows.
    task automatic send(input logic [1:0] k, input logic [7:0] b,
                        output logic v, output logic o);
        @(negedge clk);
        ev_vld = 1'b1; ev_kind = k; ev_byte = b;
        @(negedge clk);
        v = ack_vld; o = ack_ok;
        ev_vld = 1'b0;
    endtask

    task automatic send_chk(input string req, input logic [1:0] k,
                            input logic [7:0] b, input logic ev, input logic eo);
        logic v, o;
        send(k, b, v, o);
        check(req, {30'd0, v, o}, {30'd0, ev, eo});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, dyn_valid}, 32'd0);
        check("R1 enables", {29'd0, evt_en}, 32'd7);
        check("R1 ack", {31'd0, ack_vld}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic v, o;
            send(VEC[i][11:10], VEC[i][9:2], v, o);
            checks++;
            if ({v, o} !== VEC[i][1:0]) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%b expected=%b",
                         VEC[i][15:12], i, {v, o}, VEC[i][1:0]);
            end
        end
        check("R5 mask applied", {29'd0, evt_en}, 32'd2);
        check("R8 address", {25'd0, dyn_addr}, 32'h15);
        check("R8 valid", {31'd0, dyn_valid}, 32'd1);

        // R7: directed disable aimed elsewhere does nothing
        send_chk("R3", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R7", K_D, 8'h81, 1'b1, 1'b1);
        send_chk("R7 mismatch", K_D, 8'h66, 1'b1, 1'b0);
        send_chk("R7 payload", K_D, 8'h07, 1'b1, 1'b0);
        send_chk("R11", K_P, 8'h00, 1'b0, 1'b0);
        check("R7 untouched", {29'd0, evt_en}, 32'd2);

        // R7/R5: directed enable to self
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R7", K_D, 8'h80, 1'b1, 1'b1);
        send_chk("R7 match", K_D, 8'h2A, 1'b1, 1'b1);
        send_chk("R5 mask", K_D, 8'h05, 1'b1, 1'b1);
        send_chk("R11", K_P, 8'h00, 1'b0, 1'b0);
        check("R5 enabled", {29'd0, evt_en}, 32'd7);

        // R9: new address equal to broadcast rejected
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R8", K_D, 8'h88, 1'b1, 1'b1);
        send_chk("R7", K_D, 8'h2A, 1'b1, 1'b1);
        send_chk("R9 nack", K_D, 8'hFC, 1'b1, 1'b0);
        send_chk("R11", K_P, 8'h00, 1'b0, 1'b0);
        check("R9 address kept", {24'd0, dyn_valid, dyn_addr}, 32'h95);

        // R10: stop ends the command; later bytes ignored
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R10", K_D, 8'h81, 1'b1, 1'b1);
        send_chk("R10", K_P, 8'h00, 1'b0, 1'b0);
        send_chk("R10 stray", K_D, 8'h2A, 1'b1, 1'b0);
        send_chk("R10 stray", K_D, 8'h07, 1'b1, 1'b0);
        check("R10 enables", {29'd0, evt_en}, 32'd7);

        // R6: reset-address, then static answers on the next header
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R6", K_D, 8'h06, 1'b1, 1'b1);
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        check("R6 invalid", {31'd0, dyn_valid}, 32'd0);
        send_chk("R6 static", K_H, 8'h54, 1'b1, 1'b1);
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R6 old addr", K_H, 8'h2A, 1'b1, 1'b0);
        send_chk("R11", K_P, 8'h00, 1'b0, 1'b0);

        // R1: reset in the same cycle as a set-new-address payload
        send_chk("R11", K_S, 8'h00, 1'b0, 1'b0);
        send_chk("R3", K_H, 8'hFC, 1'b1, 1'b1);
        send_chk("R8", K_D, 8'h88, 1'b1, 1'b1);
        send_chk("R7", K_D, 8'h54, 1'b1, 1'b1);
        @(negedge clk);
        ev_vld = 1'b1; ev_kind = K_D; ev_byte = 8'h2A; rst_n = 1'b0;
        @(negedge clk);
        ev_vld = 1'b0;
        check("R1 reset wins valid", {31'd0, dyn_valid}, 32'd0);
        check("R1 reset wins ack", {31'd0, ack_vld}, 32'd0);
        check("R1 reset enables", {29'd0, evt_en}, 32'd7);
        rst_n = 1'b1;
        send_chk("R10 after reset", K_D, 8'h2A, 1'b1, 1'b0);
        check("R10 after reset", {31'd0, dyn_valid}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule